// File: doc/BRIEF.md
# Device Interrupt Mask and Routing

The block routes up to 64 device interrupt lines to up to four processors. A raw request register keeps one bit per device line. External set and clear strobes update it, and each strobe carries a 6-bit line number. Every processor has its own 64-bit enable mask. The processor's pending vector is the mask ANDed with the raw requests. Its interrupt output is a level signal that is high while that vector is non-zero.

Software reaches the masks, the pending vectors and the raw register through a simple request port. Each access is one cycle and carries a byte offset, a write enable and an access-size code. Fixed register slots give per-processor access. Two bulk-select offset bits instead take the processor number from offset bits [9:4]. Only 64-bit accesses are legal, with one exception: a 32-bit read of the raw register is allowed. Any unsupported access sets a sticky error flag and returns zero read data.

Top module: `irq_router`

## Requirements
- R1: After reset the raw register, every mask, every interrupt output, the read data and the error flag are all zero.
- R2: A set strobe on line L sets raw bit L. The raw register reads at offset 0x400.
- R3: A clear strobe on line L clears raw bit L. A clear of a bit that is already clear changes no state. When set and clear name the same line in one cycle, the set wins. When they name different lines, both take effect.
- R4: The pending vector of processor n equals mask n AND raw. It reads at offset 0x300 + 0x40*n. It follows every mask write and every raw change.
- R5: irq_o[n] is the OR of processor n's pending vector. It changes on the clock edge that samples the strobe or mask write. It stays stable when there is no strobe and no write.
- R6: The mask of processor n reads and writes at offset 0x200 + 0x40*n.
- R7: When offset bit 13 is set, the access targets the mask of the processor numbered by offset bits [9:4]. Bits [3:0] must then be zero.
- R8: When offset bit 13 is clear and bit 12 is set, a read returns the pending vector of the processor numbered by offset bits [9:4]. A write there is an error.
- R9: csr_size_i codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. Only 64-bit accesses are legal. The one exception is a 32-bit read of the raw register, which returns its low word zero-extended.
- R10: The following accesses are errors and change no state: writes to pending vectors, writes to the raw register, unknown indices, processor numbers at or above NUM_CPUS, a non-bulk offset with bits [5:0] not zero, and a bulk offset with bits [3:0] not zero.
- R11: A read returns its data with csr_rvalid_o one cycle after the request. An erroneous access sets err_o and returns zero read data. err_o stays high until reset, and later legal reads still return data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_set_i | input | 1 | Device line set strobe |
| dev_set_line_i | input | 6 | Line number for set |
| dev_clr_i | input | 1 | Device line clear strobe |
| dev_clr_line_i | input | 6 | Line number for clear |
| csr_req_i | input | 1 | Access request, one cycle |
| csr_we_i | input | 1 | Write enable |
| csr_size_i | input | 2 | Access size code |
| csr_addr_i | input | 14 | Byte offset |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data |
| csr_rvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | Sticky access error |
| irq_o | output | NUM_CPUS (4) | Per-processor interrupt level |

## Verification
The hardest case to reach is a mask write that crosses raw bits in both directions at once. In that case a processor's output has to drop or rise with no device strobe at all. To get there, the bench first fills the raw register through a full sweep of set strobes. It then clears lines one at a time and rewrites masks so that they hit or miss the remaining raw bits, checking every output after each step. Error cases need a fresh reset each, because the flag is sticky. Each one therefore runs from reset, and the bench then confirms through legal reads that no state changed.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;
  typedef enum logic [1:0] {K_NONE, K_MASK, K_VEC, K_RAW} acc_kind_e;
  localparam int unsigned MAX_CPUS      = 4;
  localparam int unsigned IDX_MASK      = 8;
  localparam int unsigned IDX_VEC       = IDX_MASK + MAX_CPUS;
  localparam int unsigned IDX_RAW       = IDX_VEC + MAX_CPUS;
  localparam int unsigned BULK_VEC_BIT  = 12;
  localparam int unsigned BULK_MASK_BIT = 13;
endpackage

// File: rtl/irq_raw_reg.sv
module irq_raw_reg #(
  parameter int unsigned W = 64,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [LW-1:0] set_line_i,
  input  logic          clr_i,
  input  logic [LW-1:0] clr_line_i,
  output logic [W-1:0]  raw_q_o,
  output logic [W-1:0]  raw_d_o
);
  logic [W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = set_i ? (W'(1) << set_line_i) : '0;
    clr_vec = clr_i ? (W'(1) << clr_line_i) : '0;
    // set applied after clear: set wins on the same line
    raw_d_o = (raw_q_o & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q_o <= '0;
    else         raw_q_o <= raw_d_o;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned W        = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CPUS-1:0]          mask_we_i,
  input  logic [W-1:0]                 wdata_i,
  input  logic [W-1:0]                 raw_q_i,
  input  logic [W-1:0]                 raw_d_i,
  output logic [NUM_CPUS-1:0][W-1:0]   mask_q_o,
  output logic [NUM_CPUS-1:0][W-1:0]   vec_o,
  output logic [NUM_CPUS-1:0]          irq_o
);
  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_cpu
    logic [W-1:0] mask_d;
    assign mask_d   = mask_we_i[g] ? wdata_i : mask_q_o[g];
    assign vec_o[g] = mask_q_o[g] & raw_q_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q_o[g] <= '0;
        irq_o[g]    <= 1'b0;
      end else begin
        mask_q_o[g] <= mask_d;
        // level follows next-state vector: raises/drops on the same edge
        irq_o[g]    <= |(mask_d & raw_d_i);
      end
    end
  end
endmodule

// File: rtl/irq_csr_dec.sv
module irq_csr_dec
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned W        = 64,
  parameter int unsigned ADDR_W   = 14
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [1:0]                 size_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_CPUS-1:0][W-1:0] mask_q_i,
  input  logic [NUM_CPUS-1:0][W-1:0] vec_i,
  input  logic [W-1:0]               raw_q_i,
  output logic [NUM_CPUS-1:0]        mask_we_o,
  output logic [W-1:0]               rdata_o,
  output logic                       rvalid_o,
  output logic                       err_o
);
  localparam int unsigned HW = W / 2;

  acc_kind_e  kind;
  logic [5:0] idx, cpu;
  logic       aligned, ok;
  logic [W-1:0] rd_d;

  assign idx = addr_i[BULK_VEC_BIT-1:6];

  always_comb begin
    kind    = K_NONE;
    cpu     = addr_i[9:4];
    aligned = (addr_i[3:0] == '0);
    if (addr_i[BULK_MASK_BIT]) begin
      kind = K_MASK;
    end else if (addr_i[BULK_VEC_BIT]) begin
      kind = K_VEC;
    end else begin
      aligned = (addr_i[5:0] == '0);
      if (idx >= 6'(IDX_MASK) && idx < 6'(IDX_VEC)) begin
        kind = K_MASK; cpu = idx - 6'(IDX_MASK);
      end else if (idx >= 6'(IDX_VEC) && idx < 6'(IDX_RAW)) begin
        kind = K_VEC;  cpu = idx - 6'(IDX_VEC);
      end else if (idx == 6'(IDX_RAW)) begin
        kind = K_RAW;
      end
    end
  end

  always_comb begin
    ok = 1'b0;
    if (aligned) begin
      unique case (kind)
        K_MASK:  ok = (size_i == SZ_D) && (cpu < 6'(NUM_CPUS));
        K_VEC:   ok = (size_i == SZ_D) && (cpu < 6'(NUM_CPUS)) && !we_i;
        K_RAW:   ok = !we_i && (size_i == SZ_D || size_i == SZ_W);
        default: ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    rd_d      = '0;
    mask_we_o = '0;
    for (int n = 0; n < NUM_CPUS; n++) begin
      if (ok && cpu == 6'(n)) begin
        if (kind == K_MASK) begin
          rd_d         = mask_q_i[n];
          mask_we_o[n] = req_i && we_i;
        end else if (kind == K_VEC) begin
          rd_d = vec_i[n];
        end
      end
    end
    if (ok && kind == K_RAW)
      rd_d = (size_i == SZ_D) ? raw_q_i : {{(W-HW){1'b0}}, raw_q_i[HW-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_d;
      if (req_i && !ok)   err_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned W        = 64,
  parameter int unsigned ADDR_W   = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dev_set_i,
  input  logic [$clog2(W)-1:0]  dev_set_line_i,
  input  logic                  dev_clr_i,
  input  logic [$clog2(W)-1:0]  dev_clr_line_i,
  input  logic                  csr_req_i,
  input  logic                  csr_we_i,
  input  logic [1:0]            csr_size_i,
  input  logic [ADDR_W-1:0]     csr_addr_i,
  input  logic [W-1:0]          csr_wdata_i,
  output logic [W-1:0]          csr_rdata_o,
  output logic                  csr_rvalid_o,
  output logic                  err_o,
  output logic [NUM_CPUS-1:0]   irq_o
);
  logic [W-1:0]               raw_q, raw_d;
  logic [NUM_CPUS-1:0][W-1:0] mask_q, vec;
  logic [NUM_CPUS-1:0]        mask_we;

  irq_raw_reg #(.W(W)) u_raw (
    .clk_i, .rst_ni,
    .set_i(dev_set_i), .set_line_i(dev_set_line_i),
    .clr_i(dev_clr_i), .clr_line_i(dev_clr_line_i),
    .raw_q_o(raw_q), .raw_d_o(raw_d)
  );

  irq_mask_bank #(.NUM_CPUS(NUM_CPUS), .W(W)) u_bank (
    .clk_i, .rst_ni,
    .mask_we_i(mask_we), .wdata_i(csr_wdata_i),
    .raw_q_i(raw_q), .raw_d_i(raw_d),
    .mask_q_o(mask_q), .vec_o(vec), .irq_o(irq_o)
  );

  irq_csr_dec #(.NUM_CPUS(NUM_CPUS), .W(W), .ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni,
    .req_i(csr_req_i), .we_i(csr_we_i), .size_i(csr_size_i), .addr_i(csr_addr_i),
    .mask_q_i(mask_q), .vec_i(vec), .raw_q_i(raw_q),
    .mask_we_o(mask_we), .rdata_o(csr_rdata_o), .rvalid_o(csr_rvalid_o), .err_o(err_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned W        = 64,
  parameter int unsigned ADDR_W   = 14
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 dev_set_i,
  input logic                 dev_clr_i,
  input logic                 csr_req_i,
  input logic                 csr_we_i,
  input logic [1:0]           csr_size_i,
  input logic [ADDR_W-1:0]    csr_addr_i,
  input logic [W-1:0]         csr_rdata_o,
  input logic                 csr_rvalid_o,
  input logic                 err_o,
  input logic [NUM_CPUS-1:0]  irq_o
);
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R11
  rvalid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && !csr_we_i) |=> csr_rvalid_o);
  // R11
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_req_i && !csr_we_i) |=> !csr_rvalid_o);
  // R11
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rvalid_o && $rose(err_o)) |-> (csr_rdata_o == '0));
  // R9
  narrow_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_size_i < 2'd2) |=> err_o);
  // R10
  raw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_we_i && csr_addr_i == ADDR_W'(14'h400)) |=> err_o);
  // R5
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_set_i && !dev_clr_i && !(csr_req_i && csr_we_i)) |=> $stable(irq_o));
endmodule

bind irq_router irq_router_chk #(.NUM_CPUS(NUM_CPUS), .W(W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NC = 4;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, dset, dclr, req, we;
  logic [5:0] sline, cline;
  logic [1:0] size;
  logic [13:0] addr;
  logic [63:0] wdata, rdata;
  logic rvalid, err;
  logic [NC-1:0] irq;

  irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .dev_set_i(dset), .dev_set_line_i(sline), .dev_clr_i(dclr), .dev_clr_line_i(cline),
    .csr_req_i(req), .csr_we_i(we), .csr_size_i(size), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_rvalid_o(rvalid),
    .err_o(err), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  logic [63:0] raw_m;
  logic [63:0] mask_m [NC];
  logic [63:0] rd_v;

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic logic [63:0] irq_exp();
    logic [63:0] v = '0;
    for (int n = 0; n < NC; n++) v[n] = |(mask_m[n] & raw_m);
    return v;
  endfunction

  function automatic logic [63:0] pat(input int n, input int k);
    return (64'h9E3779B97F4A7C15 * 64'(n + 1)) ^ (64'h0123456789ABCDEF << k) ^ 64'(k * 977);
  endfunction

  function automatic logic [13:0] a_mask(input int n); return 14'(14'h200 + n * 64); endfunction
  function automatic logic [13:0] a_vec(input int n);  return 14'(14'h300 + n * 64); endfunction
  localparam logic [13:0] A_RAW = 14'h400;

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dset = 0; dclr = 0; req = 0; we = 0;
    sline = '0; cline = '0; size = 2'd3; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    raw_m = '0;
    for (int n = 0; n < NC; n++) mask_m[n] = '0;
  endtask

  task automatic csr(input logic w, input logic [1:0] sz, input logic [13:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1; we = w; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic wr_mask(input logic [13:0] a, input int n, input logic [63:0] d, input string r);
    csr(1, 2'd3, a, d);
    mask_m[n] = d;
    chk(r, 64'(irq), irq_exp());
  endtask

  task automatic rd(input logic [1:0] sz, input logic [13:0] a, output logic [63:0] d);
    csr(0, sz, a, '0);
    chk("R11 rvalid", 64'(rvalid), 64'd1);
    d = rdata;
  endtask

  task automatic dev(input logic s, input int sl, input logic c, input int cl, input string r);
    @(negedge clk);
    dset = s; sline = 6'(sl); dclr = c; cline = 6'(cl);
    @(negedge clk);
    dset = 0; dclr = 0;
    if (c) raw_m &= ~(64'd1 << cl);
    if (s) raw_m |= (64'd1 << sl);
    chk(r, 64'(irq), irq_exp());
  endtask

  task automatic err_after(input string r);
    chk(r, 64'(err), 64'd1);
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 err", 64'(err), 64'd0);
    chk("R1 rdata", rdata, 64'd0);
    rd(2'd3, A_RAW, rd_v); chk("R1 raw", rd_v, 64'd0);
    for (int n = 0; n < NC; n++) begin rd(2'd3, a_mask(n), rd_v); chk("R1 mask", rd_v, 64'd0); end

    // R6 mask slots
    for (int n = 0; n < NC; n++) begin
      wr_mask(a_mask(n), n, pat(n, 0), "R6 irq");
      rd(2'd3, a_mask(n), rd_v); chk("R6 mask rd", rd_v, mask_m[n]);
    end
    // sparse masks so outputs toggle during the sweep
    for (int n = 0; n < NC; n++) wr_mask(a_mask(n), n, 64'd1 << (n * 16 + 3), "R6 sparse");

    // R2 / R5 sweep: set every line
    for (int l = 0; l < 64; l++) begin
      dev(1, l, 0, 0, "R5 set irq");
      if (l % 8 == 7) begin
        rd(2'd3, A_RAW, rd_v); chk("R2 raw", rd_v, raw_m);
        for (int n = 0; n < NC; n++) begin rd(2'd3, a_vec(n), rd_v); chk("R4 vec", rd_v, mask_m[n] & raw_m); end
      end
    end

    // R3 / R5 sweep: clear lines, spurious clears
    for (int l = 0; l < 64; l += 3) begin
      dev(0, 0, 1, l, "R3 clr irq");
      dev(0, 0, 1, l, "R3 spurious irq");
      rd(2'd3, A_RAW, rd_v); chk("R3 spurious raw", rd_v, raw_m);
    end
    dev(1, 5, 1, 5, "R3 same-line irq");
    rd(2'd3, A_RAW, rd_v); chk("R3 set wins", rd_v, raw_m);
    dev(1, 6, 1, 5, "R3 both irq");
    rd(2'd3, A_RAW, rd_v); chk("R3 both lines", rd_v, raw_m);

    // R4 / R5 mask rewrite hitting and missing raw bits
    for (int n = 0; n < NC; n++) begin
      wr_mask(a_mask(n), n, 64'd1 << 6, "R4 hit irq");
      wr_mask(a_mask(n), n, 64'd1 << 5, "R4 miss irq");
      rd(2'd3, a_vec(n), rd_v); chk("R4 vec miss", rd_v, 64'd0);
      wr_mask(a_mask(n), n, pat(n, 7), "R4 pattern irq");
      rd(2'd3, a_vec(n), rd_v); chk("R4 vec pattern", rd_v, mask_m[n] & raw_m);
    end

    // R7 bulk mask
    for (int n = 0; n < NC; n++) begin
      wr_mask(14'h2000 | 14'(n << 4), n, pat(n, 11), "R7 bulk wr irq");
      rd(2'd3, a_mask(n), rd_v); chk("R7 bulk via slot", rd_v, mask_m[n]);
      rd(2'd3, 14'h2000 | 14'(n << 4), rd_v); chk("R7 bulk rd", rd_v, mask_m[n]);
    end
    // R8 bulk vector read
    for (int n = 0; n < NC; n++) begin
      rd(2'd3, 14'h1000 | 14'(n << 4), rd_v); chk("R8 bulk vec", rd_v, mask_m[n] & raw_m);
    end
    // R9 32-bit raw read
    rd(2'd2, A_RAW, rd_v); chk("R9 low word", rd_v, {32'd0, raw_m[31:0]});
    chk("R11 no err yet", 64'(err), 64'd0);

    // R10 write raw
    do_reset(); dev(1, 3, 0, 0, "R2 pre");
    csr(1, 2'd3, A_RAW, '1); err_after("R10 raw write err");
    rd(2'd3, A_RAW, rd_v); chk("R10 raw unchanged", rd_v, raw_m);
    // R11 sticky after legal traffic
    wr_mask(a_mask(1), 1, 64'd8, "R11 irq after err");
    rd(2'd3, a_vec(1), rd_v); chk("R11 legal read after err", rd_v, 64'd8);
    chk("R11 sticky", 64'(err), 64'd1);

    // R10 write pending vector
    do_reset(); csr(1, 2'd3, a_vec(0), '1); err_after("R10 vec write err");
    rd(2'd3, a_mask(0), rd_v); chk("R10 mask untouched", rd_v, 64'd0);
    // R8 bulk vector write
    do_reset(); csr(1, 2'd3, 14'h1000, '1); err_after("R8 bulk vec write err");
    chk("R8 irq low", 64'(irq), 64'd0);
    // R9 32-bit mask read
    do_reset(); wr_mask(a_mask(2), 2, 64'hFFFF, "R9 pre");
    rd(2'd2, a_mask(2), rd_v); chk("R9 narrow data zero", rd_v, 64'd0); err_after("R9 narrow err");
    // R9 byte raw read
    do_reset(); rd(2'd0, A_RAW, rd_v); err_after("R9 byte err");
    // R10 processor number too big
    do_reset(); csr(1, 2'd3, 14'h2000 | 14'(5 << 4), '1); err_after("R10 cpu range err");
    for (int n = 0; n < NC; n++) begin rd(2'd3, a_mask(n), rd_v); chk("R10 masks unchanged", rd_v, 64'd0); end
    // R10 misaligned and unknown
    do_reset(); rd(2'd3, A_RAW | 14'h8, rd_v); chk("R10 misaligned data", rd_v, 64'd0); err_after("R10 misaligned err");
    do_reset(); rd(2'd3, 14'h0, rd_v); chk("R10 unknown data", rd_v, 64'd0); err_after("R10 unknown err");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule